// File: doc/BRIEF.md
# Half-Bridge Input Decoder with Dead-Time

This block converts a sleep/inhibit level and four per-channel logic levels into high-side and low-side gate enables for four half-bridges. Channels are grouped into two full-bridge pairs: channels 1 and 2 form one pair, and channels 3 and 4 form the other. Even-numbered channels (2 and 4) use inverted input polarity. Because of this, tying both inputs of a pair to one signal yields complementary outputs, which gives two-phase stepper drive from a single control line per pair.

Every change of a channel's driven side passes through a break-before-make interval. The interval is a parameter, `DEAD`, in clock cycles, and during it both enables of that channel are low. Fault logic can force any channel off through a per-channel disable input. That disable acts in the same cycle, with no dead-time wait.

Top module: `hbridge_deadtime_decoder`

## Requirements
- R1: While `inh` is low, every bit of `hs_en` and `ls_en` is low in the same cycle (sleep, high impedance).
- R2: Channels at `in_lvl[0]` and `in_lvl[2]` are non-inverting. Level 1 selects the high side and level 0 selects the low side.
- R3: Channels at `in_lvl[1]` and `in_lvl[3]` are inverting. Level 0 selects the high side and level 1 selects the low side.
- R4: For a pair with inputs {odd, even} = {`in_lvl[0]`, `in_lvl[1]`}, the decoding is as follows. 0:1 (the undriven default) gives both low sides on. 1:0 gives both high sides on. 0:0 gives L,H. 1:1 gives H,L. The same holds for `in_lvl[2]`/`in_lvl[3]`.
- R5: The `hs_en` and `ls_en` bits of one channel are never high together. One is never followed directly by the other at the next edge.
- R6: When the selected side differs from the side that is on, the on side drops at the next rising edge. The other side rises exactly `DEAD` rising edges after that, and both are low in between.
- R7: A high `flt_off[i]` forces channel i's enables low in the same cycle and leaves the other channels unchanged.
- R8: After reset release, wake-up from sleep, or removal of a fault disable, the channel's first switch turns on at the `DEAD`-th rising edge with the channel enabled.
- R9: If the input returns to its old value during the dead interval, the interval still runs to its end. The side selected at that end is then switched on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| inh | input | 1 | High = active, low = sleep |
| in_lvl | input | NCH | Per-channel logic input, bit 0 = channel 1 |
| flt_off | input | NCH | Per-channel forced disable from fault logic |
| hs_en | output | NCH | High-side gate enable per channel |
| ls_en | output | NCH | Low-side gate enable per channel |

## Verification
The bench applies all four level pairs to each full-bridge pair, including the undriven default and the tied-input stepper pattern. This tells the polarity of each channel apart from its neighbour's.

Direction reversals are sampled cycle by cycle. This separates a correct `DEAD`-cycle gap from a gap one cycle too short or too long. A reversal that is cancelled mid-gap shows whether the counter restarts or completes.

Sleep and per-channel fault disables are checked both in the same cycle and on release. This separates instantaneous gating from registered gating and confirms that untouched channels keep driving.

// File: rtl/hbridge_deadtime_decoder.sv
module hbridge_deadtime_decoder #(
  parameter int NCH  = 4,
  parameter int DEAD = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           inh,
  input  logic [NCH-1:0] in_lvl,
  input  logic [NCH-1:0] flt_off,
  output logic [NCH-1:0] hs_en,
  output logic [NCH-1:0] ls_en
);
  localparam int CW = (DEAD < 2) ? 1 : $clog2(DEAD);
  localparam logic [CW-1:0] RELOAD = CW'(DEAD - 1);

  function automatic logic [NCH-1:0] inv_mask();
    logic [NCH-1:0] m;
    for (int i = 0; i < NCH; i++) m[i] = (i % 2) == 1;
    return m;
  endfunction

  localparam logic [NCH-1:0] INV = inv_mask();

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic          hs_q, ls_q;
    logic [CW-1:0] cnt;
    wire want_hs = in_lvl[g] ^ INV[g];
    wire kill    = ~inh | flt_off[g];

    always_ff @(posedge clk) begin
      if (!rst_n || kill) begin
        hs_q <= 1'b0;
        ls_q <= 1'b0;
        cnt  <= RELOAD;
      end else if ((hs_q && !want_hs) || (ls_q && want_hs)) begin
        hs_q <= 1'b0;
        ls_q <= 1'b0;
        cnt  <= RELOAD;
      end else if (!hs_q && !ls_q) begin
        if (cnt != '0) cnt <= cnt - CW'(1);
        else begin
          hs_q <= want_hs;
          ls_q <= ~want_hs;
        end
      end
    end

    assign hs_en[g] = hs_q & ~kill;
    assign ls_en[g] = ls_q & ~kill;
  end
endmodule

// File: rtl/hbridge_deadtime_decoder_chk.sv
module hbridge_deadtime_decoder_chk #(
  parameter int NCH  = 4,
  parameter int DEAD = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic           inh,
  input logic [NCH-1:0] flt_off,
  input logic [NCH-1:0] hs_en,
  input logic [NCH-1:0] ls_en
);
  localparam int OW = $clog2(DEAD + 2);

  for (genvar g = 0; g < NCH; g++) begin : g_c
    logic [OW-1:0] off_cnt;
    always_ff @(posedge clk) begin
      if (!rst_n || hs_en[g] || ls_en[g]) off_cnt <= '0;
      else if (off_cnt < OW'(DEAD)) off_cnt <= off_cnt + OW'(1);
    end

    a_r1_sleep_off: assert property (@(posedge clk) disable iff (!rst_n)
      !inh |-> !hs_en[g] && !ls_en[g]);
    a_r7_fault_off: assert property (@(posedge clk) disable iff (!rst_n)
      flt_off[g] |-> !hs_en[g] && !ls_en[g]);
    a_r5_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
      !(hs_en[g] && ls_en[g]));
    a_r5_no_swap: assert property (@(posedge clk) disable iff (!rst_n)
      hs_en[g] |=> !ls_en[g]);
    a_r6_min_gap: assert property (@(posedge clk) disable iff (!rst_n)
      (hs_en[g] || ls_en[g]) && off_cnt != '0 |-> off_cnt >= OW'(DEAD));
  end
endmodule

bind hbridge_deadtime_decoder hbridge_deadtime_decoder_chk #(.NCH(NCH), .DEAD(DEAD)) u_chk (
  .clk(clk), .rst_n(rst_n), .inh(inh), .flt_off(flt_off), .hs_en(hs_en), .ls_en(ls_en)
);

// File: tb/hbridge_deadtime_decoder_tb.sv
module hbridge_deadtime_decoder_tb;
  localparam int NCH = 4, DEAD = 4;
  logic clk = 0, rst_n = 0, inh = 0;
  logic [NCH-1:0] in_lvl = 4'b1010, flt_off = '0;
  logic [NCH-1:0] hs_en, ls_en;
  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  hbridge_deadtime_decoder #(.NCH(NCH), .DEAD(DEAD)) u_dut (
    .clk(clk), .rst_n(rst_n), .inh(inh), .in_lvl(in_lvl),
    .flt_off(flt_off), .hs_en(hs_en), .ls_en(ls_en));

  task automatic cmp(string req, logic [NCH-1:0] hs_x, logic [NCH-1:0] ls_x);
    n_cmp++;
    if (hs_en !== hs_x || ls_en !== ls_x) begin
      n_bad++;
      $display("FAIL %s: hs=%b ls=%b expected hs=%b ls=%b", req, hs_en, ls_en, hs_x, ls_x);
    end
  endtask

  function automatic logic [NCH-1:0] sel_hs(logic [NCH-1:0] v);
    return v ^ 4'b1010;
  endfunction

  task automatic settle(string req, logic [NCH-1:0] v);
    @(negedge clk); in_lvl = v;
    repeat (DEAD + 2) @(negedge clk);
    cmp(req, sel_hs(v), ~sel_hs(v));
  endtask

  task automatic t_reset;
    inh = 1; rst_n = 0;
    repeat (3) @(negedge clk);
    cmp("R8 reset state", '0, '0);
    rst_n = 1;
    for (int j = 1; j < DEAD; j++) begin @(negedge clk); cmp("R8 reset wait", '0, '0); end
    @(negedge clk); cmp("R8 first on after reset", '0, '1);
  endtask

  task automatic t_decode;
    settle("R4 default brake LL", 4'b1010);
    settle("R2 R3 ch1 high ch2 low brake HH", 4'b1001);
    settle("R4 pair 0:0", 4'b0000);
    settle("R4 pair 1:1", 4'b1111);
    settle("R2 R3 tied pairs 1,0", 4'b0011);
    settle("R2 R3 tied pairs 0,1", 4'b1100);
  endtask

  task automatic t_dead;
    settle("R6 setup", 4'b1010);
    @(negedge clk); in_lvl = 4'b1011;
    for (int j = 0; j < DEAD; j++) begin @(negedge clk); cmp("R6 gap", 4'b0000, 4'b1110); end
    @(negedge clk); cmp("R6 opposite side on", 4'b0001, 4'b1110);
    @(negedge clk); in_lvl = 4'b1010;
    @(negedge clk); cmp("R9 off after edge", 4'b0000, 4'b1110);
    in_lvl = 4'b1011;
    for (int j = 1; j < DEAD; j++) begin @(negedge clk); cmp("R9 gap continues", 4'b0000, 4'b1110); end
    @(negedge clk); cmp("R9 side at end of gap", 4'b0001, 4'b1110);
  endtask

  task automatic t_sleep;
    settle("R1 setup", 4'b0011);
    @(negedge clk); inh = 0; #1;
    cmp("R1 sleep same cycle", '0, '0);
    repeat (3) @(negedge clk); cmp("R1 sleep held", '0, '0);
    inh = 1;
    for (int j = 1; j < DEAD; j++) begin @(negedge clk); cmp("R8 wake wait", '0, '0); end
    @(negedge clk); cmp("R8 wake on", 4'b1001, 4'b0110);
  endtask

  task automatic t_fault;
    @(negedge clk); flt_off = 4'b0100; #1;
    cmp("R7 fault ch3 same cycle", 4'b1001, 4'b0010);
    repeat (3) @(negedge clk); cmp("R7 others unaffected", 4'b1001, 4'b0010);
    flt_off = '0;
    for (int j = 1; j < DEAD; j++) begin @(negedge clk); cmp("R7 release wait", 4'b1001, 4'b0010); end
    @(negedge clk); cmp("R7 release on", 4'b1001, 4'b0110);
  endtask

  initial begin
    t_reset;
    t_decode;
    t_dead;
    t_sleep;
    t_fault;
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: run did not complete");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule